// File: doc/BRIEF.md
# Compare Status Flag Generator

This unit produces the six arithmetic status flags that a small 8-bit microcontroller core needs after a compare or a zero/sign test. It subtracts a second operand (a register value or an immediate) from a first operand. The difference goes nowhere: only the flags change. The updated status byte is then held in a register. The top two status bits, interrupt enable and bit-copy storage, are taken from the incoming status byte and copied through untouched.

Four operations are offered. The plain compare and the compare-against-immediate give signed-less, unsigned-lower and equality results that a conditional branch can test directly. The compare-with-carry variant subtracts the incoming carry as well. It keeps the zero flag only if zero was already set, so a multi-byte compare chains from its low byte upward. The test operation looks at the first operand alone and behaves as a logical operation. The core feeds the registered status back as the current status byte for the next operation.

Top module: `cmp_flag_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears `status_q` to 0x00, and it takes priority over `upd`.
- R2: When `upd` is low at a rising edge, `status_q` keeps its value whatever the other inputs are.
- R3: On an update, `status_q[7]` and `status_q[6]` take the values of `sreg_in[7]` and `sreg_in[6]` for every operation.
- R4: The compare (`op_sel`=00) computes `op_a - op_b`. After it, bit 0 (C) is 1 exactly when `op_a < op_b` unsigned, bit 1 (Z) is 1 exactly when `op_a == op_b`, and bit 4 (S) is 1 exactly when `op_a < op_b` signed.
- R5: For the subtracting operations, bit 2 (N) is bit 7 of the difference, bit 3 (V) is two's-complement overflow of the subtraction, and S equals N xor V.
- R6: For the subtracting operations, bit 5 (H) is 1 exactly when the low nibble subtraction (including any subtracted carry) borrows.
- R7: Compare-immediate (`op_sel`=10) uses `imm` in place of `op_b`, and `op_b` has no effect on its result.
- R8: Compare-with-carry (`op_sel`=01) computes `op_a - op_b - sreg_in[0]`. Z becomes 1 only when the difference is zero and `sreg_in[1]` is 1, otherwise Z becomes 0.
- R9: Test (`op_sel`=11) clears V, sets N to `op_a[7]`, sets Z when `op_a` is zero and sets S to N xor V. H and C are copied from `sreg_in[5]` and `sreg_in[0]`, and `op_b` and `imm` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 8 | First operand (minuend) |
| op_b | input | 8 | Second register operand (subtrahend) |
| imm | input | 8 | Immediate subtrahend for compare-immediate |
| op_sel | input | 2 | 00 compare, 01 compare-with-carry, 10 compare-immediate, 11 test |
| upd | input | 1 | Flag update strobe |
| sreg_in | input | 8 | Current status byte |
| status_q | output | 8 | Registered updated status byte |

## Verification
The properties assume that `op_sel`, the operands and `sreg_in` are steady and known whenever `upd` is high at an edge. They also assume reset is held through the first edge, so the register starts from a known value. The bench changes inputs only on falling edges and holds them across the following rising edge. It asserts reset from time zero before any update. It also feeds arbitrary status bytes, including ones whose S bit disagrees with N and V, because the result never depends on the incoming S.

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] imm,
  input  logic [1:0]   op_sel,
  input  logic         upd,
  input  logic [7:0]   sreg_in,
  output logic [7:0]   status_q
);
  localparam int MSB = W - 1;
  localparam logic [1:0] OP_CMP  = 2'b00;
  localparam logic [1:0] OP_CMPC = 2'b01;
  localparam logic [1:0] OP_CMPI = 2'b10;
  localparam logic [1:0] OP_TST  = 2'b11;

  logic         borrow_in;
  logic [W-1:0] subtrahend;
  logic [W-1:0] diff;
  logic         f_c, f_h, f_v, f_n, f_z;
  logic [5:0]   sub_flags, tst_flags, new_flags;

  assign borrow_in  = (op_sel == OP_CMPC) & sreg_in[0];
  assign subtrahend = (op_sel == OP_CMPI) ? imm : op_b;
  assign diff       = op_a - subtrahend - {{(W-1){1'b0}}, borrow_in};

  assign f_c = (~op_a[MSB] & subtrahend[MSB]) | (subtrahend[MSB] & diff[MSB]) | (diff[MSB] & ~op_a[MSB]);
  assign f_h = (~op_a[3] & subtrahend[3]) | (subtrahend[3] & diff[3]) | (diff[3] & ~op_a[3]);
  assign f_v = (op_a[MSB] & ~subtrahend[MSB] & ~diff[MSB]) | (~op_a[MSB] & subtrahend[MSB] & diff[MSB]);
  assign f_n = diff[MSB];
  assign f_z = (diff == '0) & ((op_sel != OP_CMPC) | sreg_in[1]);

  // order: H S V N Z C
  assign sub_flags = {f_h, f_n ^ f_v, f_v, f_n, f_z, f_c};
  assign tst_flags = {sreg_in[5], op_a[MSB], 1'b0, op_a[MSB], op_a == '0, sreg_in[0]};
  assign new_flags = (op_sel == OP_TST) ? tst_flags : sub_flags;

  always_ff @(posedge clk) begin
    if (rst)
      status_q <= 8'h00;
    else if (upd)
      status_q <= {sreg_in[7:6], new_flags};
  end
endmodule

module cmp_flag_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] op_a,
  input logic [7:0] op_b,
  input logic [7:0] imm,
  input logic [1:0] op_sel,
  input logic       upd,
  input logic [7:0] sreg_in,
  input logic [7:0] status_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> status_q == 8'h00);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst) !upd |=> $stable(status_q));
  // R3
  upper_pass_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> status_q[7:6] == $past(sreg_in[7:6]));
  // R4
  unsigned_lower_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && op_sel == 2'b00) |=> status_q[0] == $past(op_a < op_b));
  // R4
  equal_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && op_sel == 2'b00) |=> status_q[1] == $past(op_a == op_b));
  // R4
  signed_less_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && op_sel == 2'b00) |=> status_q[4] == $past($signed(op_a) < $signed(op_b)));
  // R5
  sign_rel_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> status_q[4] == (status_q[2] ^ status_q[3]));
  // R7
  imm_lower_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && op_sel == 2'b10) |=> status_q[0] == $past(op_a < imm));
  // R9
  tst_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && op_sel == 2'b11) |=> (status_q[5] == $past(sreg_in[5])) && (status_q[0] == $past(sreg_in[0])) && !status_q[3]);
endmodule

bind cmp_flag_unit cmp_flag_unit_chk u_chk (.*);

// File: tb/cmp_flag_unit_tb.sv
`timescale 1ns/1ps
module cmp_flag_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op_a = '0, op_b = '0, imm = '0, sreg_in = '0;
  logic [1:0] op_sel = '0;
  logic       upd = 1'b0;
  logic [7:0] status_q;
  int errors = 0;
  int checks = 0;

  cmp_flag_unit u_dut (.clk, .rst, .op_a, .op_b, .imm, .op_sel, .upd, .sreg_in, .status_q);

  always #4 clk = ~clk;

  localparam int NV = 16;
  // {op_sel, op_a, op_b, imm, sreg_in}
  localparam logic [33:0] VEC [0:NV-1] = '{
    {2'b00, 8'h05, 8'h05, 8'h00, 8'h00},
    {2'b00, 8'h03, 8'h07, 8'h00, 8'hC0},
    {2'b00, 8'h80, 8'h01, 8'h00, 8'h3F},
    {2'b00, 8'h7F, 8'hFF, 8'h00, 8'h40},
    {2'b00, 8'h10, 8'h01, 8'h00, 8'h80},
    {2'b00, 8'hFE, 8'h02, 8'h00, 8'h00},
    {2'b01, 8'h00, 8'h00, 8'h00, 8'h03},
    {2'b01, 8'h01, 8'h00, 8'h00, 8'h03},
    {2'b01, 8'h00, 8'h00, 8'h00, 8'h00},
    {2'b01, 8'h00, 8'h00, 8'h00, 8'h01},
    {2'b01, 8'h20, 8'h10, 8'h00, 8'hC3},
    {2'b10, 8'h42, 8'hAA, 8'h42, 8'h00},
    {2'b10, 8'h10, 8'h00, 8'h90, 8'h40},
    {2'b11, 8'h00, 8'h55, 8'h11, 8'h21},
    {2'b11, 8'h9C, 8'h00, 8'hFF, 8'hC8},
    {2'b11, 8'h01, 8'hFF, 8'h00, 8'h16}
  };

  function automatic logic [7:0] model(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                                       input logic [7:0] im, input logic [7:0] s);
    logic [7:0] sub;
    logic       cin, c, h, v, n, z;
    logic [8:0] d9;
    logic [4:0] d5;
    int         sd;
    if (op == 2'b11) begin
      n = a[7];
      return {s[7:6], s[5], n, 1'b0, n, a == 8'h00, s[0]};
    end
    sub = (op == 2'b10) ? im : b;
    cin = (op == 2'b01) ? s[0] : 1'b0;
    d9 = {1'b0, a} - {1'b0, sub} - {8'h00, cin};
    d5 = {1'b0, a[3:0]} - {1'b0, sub[3:0]} - {4'h0, cin};
    sd = int'($signed(a)) - int'($signed(sub)) - int'(cin);
    c = d9[8];
    h = d5[4];
    v = (sd < -128) || (sd > 127);
    n = d9[7];
    z = (d9[7:0] == 8'h00) && ((op != 2'b01) || s[1]);
    return {s[7:6], h, n ^ v, v, n, z, c};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] im, input logic [7:0] s, input logic u);
    @(negedge clk);
    op_sel = op; op_a = a; op_b = b; imm = im; sreg_in = s; upd = u;
    @(negedge clk);
    upd = 1'b0;
  endtask

  function automatic string req_of(input logic [1:0] op);
    case (op)
      2'b00: return "R4 R5 R6 R3";
      2'b01: return "R8 R5 R6 R3";
      2'b10: return "R7 R5 R6 R3";
      default: return "R9 R3";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] held;
    logic [7:0] e;
    repeat (2) @(negedge clk);
    check("R1 reset", status_q, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][33:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], 1'b1);
      check(req_of(VEC[i][33:32]), status_q,
            model(VEC[i][33:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]));
    end

    // R4 signed/unsigned/equal views on a compare
    step(2'b00, 8'hF0, 8'h10, 8'h00, 8'h00, 1'b1);
    check("R4 signed less S", {7'd0, status_q[4]}, 8'd1);
    check("R4 unsigned lower C", {7'd0, status_q[0]}, 8'd0);
    check("R5 S=N^V", {7'd0, status_q[4]}, {7'd0, status_q[2] ^ status_q[3]});

    // R7 op_b ignored under compare-immediate
    step(2'b10, 8'h33, 8'h00, 8'h34, 8'h00, 1'b1);
    held = status_q;
    step(2'b10, 8'h33, 8'hFF, 8'h34, 8'h00, 1'b1);
    check("R7 op_b ignored", status_q, held);

    // R8 two-byte chain: 0x1234 vs 0x1234 -> Z stays set
    step(2'b00, 8'h34, 8'h34, 8'h00, 8'h00, 1'b1);
    e = status_q;
    step(2'b01, 8'h12, 8'h12, 8'h00, e, 1'b1);
    check("R8 chained equal Z", {7'd0, status_q[1]}, 8'd1);
    // 0x1235 vs 0x1234 -> low differs, Z cleared
    step(2'b00, 8'h35, 8'h34, 8'h00, 8'h00, 1'b1);
    e = status_q;
    step(2'b01, 8'h12, 8'h12, 8'h00, e, 1'b1);
    check("R8 chained unequal Z", {7'd0, status_q[1]}, 8'd0);

    // R2 hold while strobe low
    step(2'b00, 8'h01, 8'h02, 8'h00, 8'hC0, 1'b1);
    held = status_q;
    step(2'b11, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    check("R2 hold", status_q, held);

    // R1 reset beats strobe
    @(negedge clk);
    rst = 1'b1; upd = 1'b1; op_sel = 2'b00; op_a = 8'h00; op_b = 8'h01; sreg_in = 8'hFF;
    @(negedge clk);
    check("R1 reset priority", status_q, 8'h00);
    rst = 1'b0; upd = 1'b0;

    // R9 test ignores op_b and imm
    step(2'b11, 8'h80, 8'h00, 8'h00, 8'h00, 1'b1);
    held = status_q;
    step(2'b11, 8'h80, 8'h7F, 8'hEE, 8'h00, 1'b1);
    check("R9 operands ignored", status_q, held);
    check("R9 value", status_q, 8'h14);

    // R6 nibble borrow with carry-in
    step(2'b01, 8'h10, 8'h00, 8'h00, 8'h01, 1'b1);
    check("R6 half borrow via carry", {7'd0, status_q[5]}, 8'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule